// File: doc/BRIEF.md
# Composite Clock Violation Decoder

This block takes a 64 kbit/s composite clock line and recovers two slower timings from it. The line has already been sliced and the bit clock recovered. One bit arrives on each cycle in which `in_valid` is high, as a positive-pulse flag and a negative-pulse flag. The line uses alternate mark inversion. Every eighth bit is a code-rule violation, meaning a pulse with the same polarity as the pulse before it. Those violations mark an 8 kHz timing.

In the richer format, the violation is left out of one slot in every twenty. That empty slot marks a 400 Hz timing. The block locks onto each layer in turn and drives a square wave for each one. It flags each bit slot that carries no pulse. It holds a loss flag high for any layer that is not locked.

The bit input is a stream with a valid strobe and no back-pressure. The block accepts a bit on every cycle in which `in_valid` is high, so an upstream stage never has to wait. Between strobes the inputs are ignored.

Top module: `cc_violation_decoder`

## Requirements
- R1: After reset, `los_8k` and `los_400` are 1 and `tick_8k`, `tick_400` and `miss_flag` are 0.
- R2: A bit with neither pulse flag set is a missing pulse, and so is a bit with both flags set. `miss_flag` goes to 1 for a missing pulse and to 0 for a real pulse. It takes the new value one clock after the strobe and holds it until the next strobe.
- R3: A violation is a pulse whose polarity equals that of the previous pulse. A violation is valid only if its polarity is opposite to that of the previous violation. `los_8k` falls on the third valid violation in a row when each is exactly 8 bits after the one before.
- R4: While locked, each eighth bit is the expected slot. A slot fails if it holds no valid violation: the pulse is missing, or the pulse follows the normal alternation. A violation outside the slot also counts as a failure. A single failure is tolerated. A valid violation in the slot clears the count. The second failure in a row sets `los_8k` to 1.
- R5: While locked, `tick_8k` is 1 for the slot bit and the 3 bits after it, then 0 for the next 4 bits. It is 0 whenever `los_8k` is 1.
- R6: With `mode_sel` = 3'b001 and the 8 kHz layer locked, `los_400` falls on a slot that follows the normal alternation when the previous such slot was exactly 20 slots earlier.
- R7: While the 400 Hz layer is locked, slot 20 after the anchor must follow the normal alternation. A stray no-violation slot elsewhere also counts as a miss. A single miss is tolerated. The second miss in a row sets `los_400` to 1.
- R8: While the 400 Hz layer is locked, `tick_400` is 1 for the first 10 of the 20 slot periods after the anchor slot and 0 for the other 10. It is 0 whenever `los_400` is 1.
- R9: With any `mode_sel` other than 3'b001, `los_400` is 1 and `tick_400` is 0 from the next clock onward. With 3'b000 the 8 kHz layer still works.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Bit strobe; one line bit per high cycle, always accepted |
| in_pos | input | 1 | Positive pulse seen in this bit |
| in_neg | input | 1 | Negative pulse seen in this bit |
| mode_sel | input | 3 | 3'b000: 64+8 kHz; 3'b001: 64+8 kHz+400 Hz |
| tick_8k | output | 1 | 8 kHz square wave |
| tick_400 | output | 1 | 400 Hz square wave |
| miss_flag | output | 1 | Last bit carried no valid pulse |
| los_8k | output | 1 | 8 kHz layer not locked |
| los_400 | output | 1 | 400 Hz layer not locked |

## Verification
The bench locks the 8 kHz layer from a random lead-in of marks and empty bits. It checks that lock comes on the third violation and not the second; a decoder with an off-by-one acquire count would lock a frame early or late. It walks one frame bit by bit to check the square wave's phase. It checks that a single no-violation slot is tolerated and that two empty slots drop lock; a decoder that dropped lock after one failure would lose 8 kHz lock once per 400 Hz cycle. For the 400 Hz layer it checks lock at exactly the second anchor and the half-period boundary of `tick_400`. It checks that lock survives one missing anchor and drops after the second. It checks the mode gate, which a decoder ignoring `mode_sel` would leave locked.

// File: rtl/ccv_pkg.sv
package ccv_pkg;
  typedef enum logic [2:0] {
    MODE_8K     = 3'b000,
    MODE_8K_400 = 3'b001
  } ccv_mode_e;

  typedef struct packed {
    logic pulse;   // exactly one polarity flag set
    logic pol;     // 1 = positive
    logic viol;    // same polarity as the previous pulse
  } ccv_bit_t;
endpackage

// File: rtl/ccv_bit_classifier.sv
module ccv_bit_classifier (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_pos,
  input  logic            in_neg,
  output ccv_pkg::ccv_bit_t cls,
  output logic            miss_q
);
  logic last_pos, have_mark;

  always_comb begin
    cls.pulse = in_pos ^ in_neg;
    cls.pol   = in_pos;
    cls.viol  = cls.pulse && have_mark && (in_pos == last_pos);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_pos  <= 1'b0;
      have_mark <= 1'b0;
      miss_q    <= 1'b0;
    end else if (in_valid) begin
      miss_q <= !cls.pulse;
      if (cls.pulse) begin
        last_pos  <= in_pos;
        have_mark <= 1'b1;
      end
    end
  end

  assert_flag_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(miss_q));
endmodule

// File: rtl/ccv_frame_lock.sv
module ccv_frame_lock #(
  parameter int SLOT_BITS  = 8,
  parameter int ACQ_COUNT  = 3,
  parameter int LOSS_COUNT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  ccv_pkg::ccv_bit_t cls,
  output logic              locked,
  output logic [$clog2(2*SLOT_BITS)-1:0] phase,
  output logic              slot_evt,
  output logic              slot_nv
);
  localparam int PHW = $clog2(2*SLOT_BITS);
  localparam int GW  = $clog2(ACQ_COUNT+1);
  localparam int MW  = $clog2(LOSS_COUNT+1);
  localparam logic [PHW-1:0] PH_SLOT = PHW'(SLOT_BITS-1);
  localparam logic [PHW-1:0] PH_MAX  = '1;

  logic          have_v, last_vpos, valid_v, at_slot, bad;
  logic [GW-1:0] good;
  logic [MW-1:0] miss;

  always_comb begin
    valid_v  = cls.viol && (!have_v || (cls.pol != last_vpos));
    at_slot  = (phase == PH_SLOT);
    slot_evt = in_valid && locked && at_slot;
    slot_nv  = slot_evt && cls.pulse && !cls.viol;
    bad      = at_slot ? !valid_v : cls.viol;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_v    <= 1'b0;
      last_vpos <= 1'b0;
      locked    <= 1'b0;
      phase     <= PH_MAX;
      good      <= '0;
      miss      <= '0;
    end else if (in_valid) begin
      if (cls.viol) begin
        have_v    <= 1'b1;
        last_vpos <= cls.pol;
      end
      if (!locked) begin
        if (cls.viol) begin
          phase <= '0;
          if (valid_v && have_v && at_slot && good != '0) begin
            if (good == GW'(ACQ_COUNT-1)) begin
              locked <= 1'b1;
              miss   <= '0;
            end
            good <= good + 1'b1;
          end else begin
            good <= GW'(1);
          end
        end else if (phase != PH_MAX) begin
          phase <= phase + 1'b1;
        end
      end else begin
        phase <= at_slot ? '0 : phase + 1'b1;
        if (at_slot && valid_v) begin
          miss <= '0;
        end else if (bad) begin
          if (miss == MW'(LOSS_COUNT-1)) begin
            locked <= 1'b0;
            good   <= '0;
            miss   <= '0;
            phase  <= PH_MAX;
          end else begin
            miss <= miss + 1'b1;
          end
        end
      end
    end
  end

  assert_lock_on_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(in_valid));
  assert_phase_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (phase <= PH_SLOT));
endmodule

// File: rtl/ccv_super_lock.sv
module ccv_super_lock #(
  parameter int SLOTS      = 20,
  parameter int LOSS_COUNT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic slot_evt,
  input  logic slot_nv,
  output logic locked,
  output logic [$clog2(2*SLOTS)-1:0] count
);
  localparam int SCW = $clog2(2*SLOTS);
  localparam int MW  = $clog2(LOSS_COUNT+1);
  localparam logic [SCW-1:0] SC_LAST = SCW'(SLOTS-1);

  logic          nv_seen, at_anchor;
  logic [MW-1:0] miss;

  assign at_anchor = (count == SC_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      locked  <= 1'b0;
      nv_seen <= 1'b0;
      count   <= '0;
      miss    <= '0;
    end else if (slot_evt) begin
      if (!locked) begin
        if (slot_nv) begin
          count   <= '0;
          nv_seen <= 1'b1;
          if (nv_seen && at_anchor) begin
            locked <= 1'b1;
            miss   <= '0;
          end
        end else if (count != '1) begin
          count <= count + 1'b1;
        end
      end else begin
        count <= at_anchor ? '0 : count + 1'b1;
        if (at_anchor && slot_nv) begin
          miss <= '0;
        end else if (at_anchor || slot_nv) begin
          if (miss == MW'(LOSS_COUNT-1)) begin
            locked  <= 1'b0;
            nv_seen <= 1'b0;
            count   <= '0;
            miss    <= '0;
          end else begin
            miss <= miss + 1'b1;
          end
        end
      end
    end
  end

  assert_count_in_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (count <= SC_LAST));
endmodule

// File: rtl/cc_violation_decoder.sv
module cc_violation_decoder #(
  parameter int SLOT_BITS   = 8,
  parameter int SUPER_SLOTS = 20,
  parameter int ACQ_8K      = 3,
  parameter int LOSS_8K     = 2,
  parameter int LOSS_400    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_pos,
  input  logic       in_neg,
  input  logic [2:0] mode_sel,
  output logic       tick_8k,
  output logic       tick_400,
  output logic       miss_flag,
  output logic       los_8k,
  output logic       los_400
);
  import ccv_pkg::*;
  localparam int PHW = $clog2(2*SLOT_BITS);
  localparam int SCW = $clog2(2*SUPER_SLOTS);

  ccv_bit_t       cls;
  logic           lock8, lock400, slot_evt, slot_nv, super_en;
  logic [PHW-1:0] phase;
  logic [SCW-1:0] scount;

  ccv_bit_classifier u_cls (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pos(in_pos),
    .in_neg(in_neg), .cls(cls), .miss_q(miss_flag)
  );

  ccv_frame_lock #(.SLOT_BITS(SLOT_BITS), .ACQ_COUNT(ACQ_8K),
                   .LOSS_COUNT(LOSS_8K)) u_frame (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cls(cls),
    .locked(lock8), .phase(phase), .slot_evt(slot_evt), .slot_nv(slot_nv)
  );

  assign super_en = (mode_sel == MODE_8K_400) && lock8;

  ccv_super_lock #(.SLOTS(SUPER_SLOTS), .LOSS_COUNT(LOSS_400)) u_super (
    .clk(clk), .rst_n(rst_n), .enable(super_en), .slot_evt(slot_evt),
    .slot_nv(slot_nv), .locked(lock400), .count(scount)
  );

  assign tick_8k  = lock8 && (phase < PHW'(SLOT_BITS/2));
  assign tick_400 = lock400 && (scount < SCW'(SUPER_SLOTS/2));
  assign los_8k   = !lock8;
  assign los_400  = !lock400;

  assert_layer_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    los_8k |=> los_400);
  assert_mode_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != MODE_8K_400) |=> (los_400 && !tick_400));
endmodule

// File: tb/sim_cc_violation_decoder.sv
module sim_cc_violation_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_pos = 1'b0, in_neg = 1'b0;
  logic [2:0] mode_sel = 3'b000;
  logic tick_8k, tick_400, miss_flag, los_8k, los_400;
  int checks = 0, errors = 0;
  logic lp = 1'b0;   // polarity of last pulse sent, 1 = positive
  bit done = 1'b0;

  always #4 clk = ~clk;

  cc_violation_decoder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pos(in_pos),
    .in_neg(in_neg), .mode_sel(mode_sel), .tick_8k(tick_8k),
    .tick_400(tick_400), .miss_flag(miss_flag), .los_8k(los_8k),
    .los_400(los_400)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic send(input logic p, input logic n);
    @(negedge clk); in_valid = 1'b1; in_pos = p; in_neg = n;
    @(negedge clk); in_valid = 1'b0; in_pos = 1'b0; in_neg = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic mark();   send(!lp, lp); lp = !lp; endtask
  task automatic viol();   send(lp, !lp);          endtask
  task automatic gap();    send(1'b0, 1'b0);       endtask

  // kind: 0 violation slot, 1 normal-alternation slot, 2 empty slot
  task automatic frame(input int kind);
    for (int i = 0; i < 7; i++) mark();
    if (kind == 0) viol(); else if (kind == 1) mark(); else gap();
  endtask

  function automatic int slot_kind(input int k);
    if (k == 60 || k == 80) return 0;
    return (k % 20 == 0) ? 1 : 0;
  endfunction

  function automatic logic exp_tick400(input int k);
    int since;
    since = (k - 20) % 20;
    return (k >= 20 && k < 60 && since < 10) ? 1'b1 : 1'b0;
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned s;
    int lead;
    s = $urandom(32'd2718);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 los_8k", los_8k, 1'b1);
    chk("R1 los_400", los_400, 1'b1);
    chk("R1 tick_8k", tick_8k, 1'b0);
    chk("R1 tick_400", tick_400, 1'b0);
    chk("R1 miss_flag", miss_flag, 1'b0);

    // random lead-in of marks and empty bits
    lp = 1'($urandom % 2);
    lead = 4 + int'($urandom % 12);
    for (int i = 0; i < lead; i++) begin
      if ($urandom % 3 == 0) begin gap(); chk("R2 empty bit", miss_flag, 1'b1); end
      else begin mark(); chk("R2 real pulse", miss_flag, 1'b0); end
    end
    send(1'b1, 1'b1);
    chk("R2 both flags", miss_flag, 1'b1);
    mark();
    chk("R2 clear", miss_flag, 1'b0);

    // R3 acquisition
    frame(0); chk("R3 first viol", los_8k, 1'b1);
    frame(0); chk("R3 second viol", los_8k, 1'b1);
    frame(0); chk("R3 third viol", los_8k, 1'b0);
    chk("R5 slot high", tick_8k, 1'b1);

    // R5 phase walk
    for (int i = 0; i < 7; i++) begin
      mark();
      chk("R5 tick_8k phase", tick_8k, (i < 3) ? 1'b1 : 1'b0);
    end
    viol(); chk("R5 tick_8k slot", tick_8k, 1'b1);

    // R4 tolerance and loss
    frame(1); chk("R4 one normal slot kept", los_8k, 1'b0);
    frame(0); chk("R4 recovered", los_8k, 1'b0);
    frame(2); chk("R4 one empty slot kept", los_8k, 1'b0);
    frame(2); chk("R4 two empty slots lost", los_8k, 1'b1);
    chk("R5 tick_8k quiet", tick_8k, 1'b0);

    // relock with 400 Hz format stream in 000 mode (R9)
    frame(0); frame(0); frame(0);
    chk("R3 relock", los_8k, 1'b0);

    mode_sel = 3'b001;
    for (int k = 0; k <= 120; k++) begin
      frame(slot_kind(k));
      if (k == 19) chk("R6 before second anchor", los_400, 1'b1);
      if (k == 20) chk("R6 lock at second anchor", los_400, 1'b0);
      if (k == 29 || k == 30 || k == 39 || k == 40)
        chk("R8 tick_400 phase", tick_400, exp_tick400(k));
      if (k == 60) chk("R7 one missed anchor kept", los_400, 1'b0);
      if (k == 80) chk("R7 two missed anchors lost", los_400, 1'b1);
      if (k == 85) chk("R8 tick_400 quiet", tick_400, 1'b0);
      if (k == 100 || k == 120) chk("R4 8k kept over nV", los_8k, 1'b0);
      if (k == 120) chk("R6 relock", los_400, 1'b0);
    end

    @(negedge clk); mode_sel = 3'b000;
    @(negedge clk); @(negedge clk);
    chk("R9 mode gate los", los_400, 1'b1);
    chk("R9 mode gate tick", tick_400, 1'b0);
    frame(0);
    chk("R9 8k still locked", los_8k, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule